// File: doc/BRIEF.md
# Line Stride Address Monitor

This block sits beside the write-address channel of a line-oriented writer (an image line store, for example) and watches it without driving anything. It also watches the writer's 32-bit line counter and a stride value that software programs. When the line counter is one, the block records the address of the first accepted address handshake. It then waits, for as many cycles as it takes, for the first accepted handshake while the counter is two. At that point it checks that the second address minus the first, taken modulo 2^40, equals the stride.

The result is reported once and then held. `done` rises together with exactly one of `pass`, `fail` or `missed`, and all of them stay set until the next synchronous reset. The check runs a single time per reset and does not re-arm on later lines. If the line counter moves beyond two before any handshake is accepted at two, the block reports `missed` and does not wait for ever.

The controller moves through five named states. **IDLE** waits for the first capture and goes to **GOT_ADDR0** on a handshake at line one. From **GOT_ADDR0** there are three exits: a handshake at line two whose difference equals the stride goes to **DONE_PASS**, the same handshake with any other difference goes to **DONE_FAIL**, and a line count above two with no such handshake goes to **DONE_MISS**. The three DONE states are terminal, and only reset leaves them.

Top module: `line_stride_monitor`

## Requirements
- R1: A synchronous active-high reset returns the controller to IDLE, clears the stored first address, and drives `done`, `pass`, `fail` and `missed` low from the first clock edge after reset is sampled. At most one of `pass`, `fail` and `missed` is ever high.
- R2: In IDLE, the first rising clock edge that sees `aw_valid`=1, `aw_ready`=1 and `line_cnt`=1 stores `aw_addr` as the first address and moves to GOT_ADDR0.
- R3: Once the first address is stored, it does not change until reset, whatever handshakes follow. An edge where only one of `aw_valid` or `aw_ready` is high captures nothing.
- R4: In GOT_ADDR0, the first edge with a handshake and `line_cnt`=2 is the second capture. Handshakes after it are ignored.
- R5: At the second capture, the 40-bit difference (second address minus first, wrapping modulo 2^40) is compared with `stride` as sampled on that same edge. Equal leads to DONE_PASS and unequal leads to DONE_FAIL.
- R6: When the second capture happens on clock edge k, `done` and the verdict output are low after edge k and high after edge k+1.
- R7: The verdict outputs and `done` hold their values until reset. Later line counts and handshakes start no new check.
- R8: The line count is compared on all 32 bits. For example, 0x0001_0001 does not count as line one, and 3 does not count as line two.
- R9: In GOT_ADDR0, an edge with `line_cnt` greater than 2 (unsigned) and no handshake at line two moves to DONE_MISS. `missed` and `done` then rise with the same one-edge delay as in R6, and `pass` and `fail` stay low.
- R10: The wait between the two captures has no cycle limit. GOT_ADDR0 holds for any number of cycles while `line_cnt` stays at 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Observed write-address valid |
| aw_ready | input | 1 | Observed write-address ready |
| aw_addr | input | 40 | Observed write address |
| line_cnt | input | 32 | Writer's current line number |
| stride | input | 40 | Programmed expected address step between line one and line two |
| done | output | 1 | The single check has finished (any verdict) |
| pass | output | 1 | The address difference matched the stride |
| fail | output | 1 | The address difference did not match the stride |
| missed | output | 1 | The line count went beyond two before a handshake at line two |

## Verification
The properties assume that the inputs are settled at every rising edge and that the line counter comes up through one before it reaches two. A counter that jumps straight from zero to three leaves the block in IDLE, and the properties say nothing about that case. The properties also assume that nothing outside a reset moves the monitor out of a DONE state. The stimulus drives every input on the falling edge and begins each scenario with a reset. It moves the line count through values chosen on purpose: 0x0001_0001, then 1, then 2, then 3 or 5. It puts partial handshakes and repeated handshakes between these steps, and it holds GOT_ADDR0 for several hundred idle cycles. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_GOT_ADDR0 = 3'd1,
        ST_DONE_PASS = 3'd2,
        ST_DONE_FAIL = 3'd3,
        ST_DONE_MISS = 3'd4
    } lsm_state_e;

    function automatic logic is_terminal(input lsm_state_e s);
        return (s == ST_DONE_PASS) || (s == ST_DONE_FAIL) || (s == ST_DONE_MISS);
    endfunction

endpackage

// File: rtl/lsm_line_qual.sv
// Qualifies accepted address handshakes against the full line number.
module lsm_line_qual #(
    parameter int CNT_W       = 32,
    parameter int FIRST_LINE  = 1,
    parameter int SECOND_LINE = 2
) (
    input  logic             aw_valid,
    input  logic             aw_ready,
    input  logic [CNT_W-1:0] line_cnt,
    output logic             hit_first,
    output logic             hit_second,
    output logic             beyond_second
);
    localparam logic [CNT_W-1:0] FIRST_V  = CNT_W'(FIRST_LINE);
    localparam logic [CNT_W-1:0] SECOND_V = CNT_W'(SECOND_LINE);

    logic accepted;

    always_comb begin
        accepted      = aw_valid && aw_ready;
        // whole-word comparisons: no single-bit shortcuts
        hit_first     = accepted && (line_cnt == FIRST_V);
        hit_second    = accepted && (line_cnt == SECOND_V);
        beyond_second = (line_cnt > SECOND_V);
    end

endmodule

// File: rtl/lsm_addr_hold.sv
// Load-once address register with synchronous clear.
module lsm_addr_hold #(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lsm_stride_cmp.sv
// Modular difference of two addresses compared against the programmed step.
module lsm_stride_cmp #(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] step,
    output logic              match
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = cur_addr - base_addr;   // wraps modulo 2^ADDR_W
        match = (delta == step);
    end

endmodule

// File: rtl/lsm_fsm.sv
// Controller: one capture at line one, one verdict at line two.
module lsm_fsm
    import lsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_first,
    input  logic       hit_second,
    input  logic       beyond_second,
    input  logic       step_ok,
    output lsm_state_e state,
    output logic       load_base
);
    lsm_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        load_base = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hit_first) begin
                    load_base = 1'b1;
                    state_nx  = ST_GOT_ADDR0;
                end
            end
            ST_GOT_ADDR0: begin
                if (hit_second) begin
                    state_nx = step_ok ? ST_DONE_PASS : ST_DONE_FAIL;
                end else if (beyond_second) begin
                    state_nx = ST_DONE_MISS;
                end
            end
            ST_DONE_PASS,
            ST_DONE_FAIL,
            ST_DONE_MISS: begin
                state_nx = state;   // terminal until reset
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/line_stride_monitor.sv
module line_stride_monitor
    import lsm_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int CNT_W       = 32,
    parameter int FIRST_LINE  = 1,
    parameter int SECOND_LINE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [CNT_W-1:0]  line_cnt,
    input  logic [ADDR_W-1:0] stride,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              missed
);
    logic              hit_first;
    logic              hit_second;
    logic              beyond_second;
    logic              load_base;
    logic              step_ok;
    logic [ADDR_W-1:0] base_q;
    lsm_state_e        state;

    lsm_line_qual #(
        .CNT_W       (CNT_W),
        .FIRST_LINE  (FIRST_LINE),
        .SECOND_LINE (SECOND_LINE)
    ) u_qual (
        .aw_valid      (aw_valid),
        .aw_ready      (aw_ready),
        .line_cnt      (line_cnt),
        .hit_first     (hit_first),
        .hit_second    (hit_second),
        .beyond_second (beyond_second)
    );

    lsm_addr_hold #(
        .ADDR_W (ADDR_W)
    ) u_base (
        .clk  (clk),
        .rst  (rst),
        .load (load_base),
        .d    (aw_addr),
        .q    (base_q)
    );

    lsm_stride_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .base_addr (base_q),
        .cur_addr  (aw_addr),
        .step      (stride),
        .match     (step_ok)
    );

    lsm_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .hit_first     (hit_first),
        .hit_second    (hit_second),
        .beyond_second (beyond_second),
        .step_ok       (step_ok),
        .state         (state),
        .load_base     (load_base)
    );

    // Output register: verdict follows the state one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            pass   <= 1'b0;
            fail   <= 1'b0;
            missed <= 1'b0;
        end else begin
            done   <= is_terminal(state);
            pass   <= (state == ST_DONE_PASS);
            fail   <= (state == ST_DONE_FAIL);
            missed <= (state == ST_DONE_MISS);
        end
    end

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker
    import lsm_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int CNT_W       = 32,
    parameter int SECOND_LINE = 2,
    parameter int FIRST_LINE  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [ADDR_W-1:0] aw_addr,
    input logic [CNT_W-1:0]  line_cnt,
    input logic [ADDR_W-1:0] stride,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              missed,
    input lsm_state_e        state,
    input logic [ADDR_W-1:0] base_q
);
    logic [ADDR_W-1:0] seen_delta;
    logic              hs;
    logic              at_two;
    logic              past_two;
    logic              at_one;

    always_comb begin
        seen_delta = aw_addr - base_q;
        hs         = aw_valid && aw_ready;
        at_one     = (line_cnt == CNT_W'(FIRST_LINE));
        at_two     = (line_cnt == CNT_W'(SECOND_LINE));
        past_two   = (line_cnt > CNT_W'(SECOND_LINE));
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && base_q == '0 && !done));

    a_r1_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, fail, missed}));

    a_r2_first_capture: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hs && at_one) |=>
            (state == ST_GOT_ADDR0 && base_q == $past(aw_addr)));

    a_r3_base_frozen: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(base_q));

    a_r5_pass_verdict: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT_ADDR0 && hs && at_two && seen_delta == stride) |=>
            ##1 (done && pass));

    a_r5_fail_verdict: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT_ADDR0 && hs && at_two && seen_delta != stride) |=>
            ##1 (done && fail));

    a_r6_no_early_done: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT_ADDR0) |=> !done);

    a_r7_done_held: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r7_verdict_held: assert property (@(posedge clk) disable iff (rst)
        (pass || fail || missed) |=> ($stable(pass) && $stable(fail) && $stable(missed)));

    a_r9_missed_flag: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT_ADDR0 && !(hs && at_two) && past_two) |=>
            ##1 (done && missed && !pass && !fail));

    a_r10_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOT_ADDR0 && !past_two && !(hs && at_two)) |=>
            (state == ST_GOT_ADDR0));

endmodule

bind line_stride_monitor lsm_checker #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .SECOND_LINE (SECOND_LINE),
    .FIRST_LINE  (FIRST_LINE)
) u_lsm_checker (
    .clk      (clk),
    .rst      (rst),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_addr  (aw_addr),
    .line_cnt (line_cnt),
    .stride   (stride),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .missed   (missed),
    .state    (state),
    .base_q   (base_q)
);

// File: tb/line_stride_monitor_test.sv
`timescale 1ns/1ps
module line_stride_monitor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        aw_valid = 1'b0;
    logic        aw_ready = 1'b0;
    logic [39:0] aw_addr = '0;
    logic [31:0] line_cnt = '0;
    logic [39:0] stride = '0;
    logic        done, pass, fail, missed;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    line_stride_monitor uut (
        .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .line_cnt(line_cnt), .stride(stride),
        .done(done), .pass(pass), .fail(fail), .missed(missed)
    );

    // Behavioural reference: phase 0 wait, 1 have first, 2 pass, 3 fail, 4 miss
    int          m_phase = 0;
    logic [39:0] m_first = '0;
    logic        e_done = 0, e_pass = 0, e_fail = 0, e_miss = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            m_first = '0;
            e_done = 0; e_pass = 0; e_fail = 0; e_miss = 0;
        end else begin
            e_done = (m_phase >= 2);
            e_pass = (m_phase == 2);
            e_fail = (m_phase == 3);
            e_miss = (m_phase == 4);
            if (m_phase == 0) begin
                if (aw_valid && aw_ready && line_cnt == 32'd1) begin
                    m_first = aw_addr;
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (aw_valid && aw_ready && line_cnt == 32'd2) begin
                    logic [39:0] d;
                    d = aw_addr - m_first;
                    m_phase = (d == stride) ? 2 : 3;
                end else if (line_cnt > 32'd2) begin
                    m_phase = 4;
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        n_tests++;
        if ({done, pass, fail, missed} !== {e_done, e_pass, e_fail, e_miss}) begin
            n_fail++;
            $display("FAIL %s cycle compare: got done/pass/fail/missed=%b%b%b%b expected %b%b%b%b",
                     cur_req, done, pass, fail, missed, e_done, e_pass, e_fail, e_miss);
        end
    end

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: done/pass/fail/missed got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic v, input logic r, input logic [31:0] c, input logic [39:0] a);
        aw_valid = v; aw_ready = r; line_cnt = c; aw_addr = a;
        @(negedge clk);
        aw_valid = 0; aw_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; aw_valid = 0; aw_ready = 0; line_cnt = 0;
        step(2);
        rst = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        step(3);
        rst = 0;
        step(1);
        check("R1", {done, pass, fail, missed}, 4'b0000);

        // Pass path with repeats, partial handshakes, long wait, no re-arm
        do_reset();
        cur_req = "R2";
        stride = 40'h50_00;
        drive(1, 0, 32'd1, 40'h11_0000_0000);   // valid only: ignored (R3)
        drive(0, 1, 32'd1, 40'h22_0000_0000);   // ready only: ignored (R3)
        drive(1, 1, 32'd1, 40'h12_3400_0000);   // first capture (R2)
        cur_req = "R3";
        drive(1, 1, 32'd1, 40'h77_0000_0000);   // later at line 1: ignored
        cur_req = "R10";
        line_cnt = 32'd2;
        step(300);                               // unbounded wait
        check("R10", {done, pass, fail, missed}, 4'b0000);
        cur_req = "R6";
        drive(1, 1, 32'd2, 40'h12_3400_5000);   // second capture at edge k
        check("R6", {done, pass, fail, missed}, 4'b0000);  // after edge k
        step(1);
        check("R6", {done, pass, fail, missed}, 4'b1100);  // after edge k+1
        cur_req = "R4";
        drive(1, 1, 32'd2, 40'h00_0000_0000);   // extra handshake at line 2
        check("R4", {done, pass, fail, missed}, 4'b1100);
        cur_req = "R7";
        drive(1, 1, 32'd3, 40'h0);
        drive(1, 1, 32'd1, 40'h0);
        drive(1, 1, 32'd2, 40'h9);
        step(3);
        check("R7", {done, pass, fail, missed}, 4'b1100);

        // Wrong stride -> fail
        do_reset();
        cur_req = "R5";
        stride = 40'h50_00;
        drive(1, 1, 32'd1, 40'h00_0010_0000);
        drive(1, 1, 32'd2, 40'h00_0010_4000);
        step(1);
        check("R5", {done, pass, fail, missed}, 4'b1010);

        // Modular difference across address wrap
        do_reset();
        drive(1, 1, 32'd1, 40'hFF_FFFF_F000);
        drive(1, 1, 32'd2, 40'h00_0000_4000);
        step(1);
        check("R5", {done, pass, fail, missed}, 4'b1100);

        // Stride reprogrammed between the lines: latest value is used
        do_reset();
        stride = 40'h10_00;
        drive(1, 1, 32'd1, 40'h05_0000_0000);
        step(5);
        stride = 40'h50_00;
        drive(1, 1, 32'd2, 40'h05_0000_5000);
        step(1);
        check("R5", {done, pass, fail, missed}, 4'b1100);

        // R8: upper count bits matter
        do_reset();
        cur_req = "R8";
        stride = 40'h20_00;
        drive(1, 1, 32'h0001_0001, 40'h33_0000_0000);   // not line one
        drive(1, 1, 32'd1, 40'h44_0000_0000);
        drive(1, 1, 32'h0001_0002, 40'h44_0000_2000);   // not line two -> miss
        step(1);
        check("R8", {done, pass, fail, missed}, 4'b1001);

        do_reset();
        stride = 40'h20_00;
        drive(1, 1, 32'h0001_0001, 40'h33_0000_0000);
        drive(1, 1, 32'd1, 40'h44_0000_0000);
        drive(1, 1, 32'd2, 40'h44_0000_2000);
        step(1);
        check("R8", {done, pass, fail, missed}, 4'b1100);

        // R9: count skips past two, later line 2 handshake ignored
        do_reset();
        cur_req = "R9";
        drive(1, 1, 32'd1, 40'h01_0000_0000);
        drive(0, 0, 32'd5, 40'h0);               // skip at edge k
        check("R9", {done, pass, fail, missed}, 4'b0000);
        step(1);
        check("R9", {done, pass, fail, missed}, 4'b1001);
        drive(1, 1, 32'd2, 40'h01_0000_5000);
        step(2);
        check("R7", {done, pass, fail, missed}, 4'b1001);

        // R1: reset clears a held verdict
        do_reset();
        cur_req = "R1";
        step(1);
        check("R1", {done, pass, fail, missed}, 4'b0000);

        finish_run();
    end

endmodule